// File: doc/BRIEF.md
# Noise-Shaping SAR Conversion Sequencer

This block is the digital controller of a 12-bit successive-approximation converter. The converter has a split binary capacitor array and one extra capacitor that carries the residue of each conversion into the next. The sequencer drives three analogue switches: the top-plate sampling switch, the bottom-plate sampling switch, and the residue (noise-shaping) switch. It also drives one three-state control per array bit: mid-rail, supply or ground. The analogue array, the comparator and the references sit outside the block.

A start in the idle state begins one conversion. First comes a sampling window, in which the top plate opens one cycle before the bottom plate. Then comes a dead-time gap. The conversion phase follows: the residue capacitor is shared with the array, and one comparator decision is taken per cycle. The first decision is taken with every bit at mid-rail. Each later decision steers one more bit, most significant first, so twelve trials produce thirteen decisions. The decisions leave the block as a serial stream as soon as they are taken, and a done strobe marks the last one. Before the top plate can return to mid-rail, the residue capacitor is opened again. With noise shaping disabled, the residue switch never closes and the rest of the sequence stays the same.

Top module: `nssar_seq`

## Requirements
- R1: While reset is applied, and in idle after it, all three switch outputs are low, every bit control is at mid-rail (`dac_up_o` and `dac_dn_o` both zero), and `ser_vld_o` and `done_o` are low.
- R2: `start_i` is taken only when it is high at a clock edge in idle; a start seen in any other phase (sampling, gap, conversion, final cycle) is ignored, and the block returns to idle after the final cycle with no new sampling.
- R3: For SAMPLE_CYCLES cycles after acceptance, the top-plate and bottom-plate switches are both closed. The top-plate switch then opens, and the bottom-plate switch stays closed alone for one more cycle. Throughout, the residue switch is open and every bit control is at mid-rail.
- R4: After the bottom-plate switch opens, GAP_CYCLES cycles follow in which all three switches are open and every bit control is at mid-rail, before any conversion activity.
- R5: When noise shaping was enabled at acceptance, the residue switch is closed during exactly the NBITS+1 conversion cycles. It is open in every other cycle, and always open when shaping was disabled.
- R6: In conversion cycle 0 every bit is at mid-rail. The decision sampled at the end of conversion cycle t (t < NBITS) sets bit NBITS-1-t: a comparator value of 1 drives it to supply (`dac_up_o` bit = 1), and 0 drives it to ground (`dac_dn_o` bit = 1). The bit holds that value from cycle t+1 to the end of conversion. A bit is never driven both ways.
- R7: `ser_vld_o` is high in the NBITS+1 cycles following conversion cycle 0. In each of these cycles, `ser_o` carries the comparator value sampled at the preceding edge, first decision first.
- R8: `done_o` is a single-cycle pulse that coincides with the last serial bit. In that cycle all switches are open and every bit control is at mid-rail, and the block is idle in the next cycle.
- R9: `ns_en_i` is read only at start acceptance; changing it later has no effect on the conversion in progress.
- R10: `cmp_i` is ignored outside the conversion phase: it changes no bit control and no serial output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Conversion request, taken only in idle |
| ns_en_i | input | 1 | Noise-shaping enable, captured at acceptance |
| cmp_i | input | 1 | Comparator decision, 1 = steer the next bit to supply |
| sw_top_o | output | 1 | Top-plate sampling switch closed |
| sw_bot_o | output | 1 | Bottom-plate sampling switch closed |
| sw_ns_o | output | 1 | Residue capacitor switch closed |
| dac_up_o | output | NBITS | Per-bit drive to supply |
| dac_dn_o | output | NBITS | Per-bit drive to ground |
| ser_o | output | 1 | Serial decision stream, first decision first |
| ser_vld_o | output | 1 | `ser_o` carries a decision |
| done_o | output | 1 | Last decision of the conversion |

## Verification
Counting from the edge that accepts a start, sampling is visible one cycle later. The hold cycle follows SAMPLE_CYCLES cycles after that, and conversion cycle 0 is cycle SAMPLE_CYCLES+GAP_CYCLES+2. Decision j appears on the serial output one cycle after the conversion cycle in which it was driven, and done shares the cycle of decision NBITS. The bench numbers every cycle of a conversion from the accepting edge. It computes the full expected switch and bit-control state for that cycle index and the comparator pattern, and it compares them at the falling edge, away from the edge where they change. The patterns sweep the thirteen-bit decision space in steps of three, with the enable alternating, and every other pair of conversions adds extra starts, enable flips and comparator toggling outside conversion.

// File: rtl/nssar_pkg.sv
package nssar_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SAMPLE,
    PH_HOLD,
    PH_GAP,
    PH_CONV,
    PH_POST
  } phase_e;
endpackage

// File: rtl/nssar_phase_ctl.sv
module nssar_phase_ctl
  import nssar_pkg::*;
#(
  parameter int NBITS         = 12,
  parameter int SAMPLE_CYCLES = 4,
  parameter int GAP_CYCLES    = 1,
  parameter int CW            = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ns_en_i,
  output phase_e        phase_o,
  output logic [CW-1:0] cnt_o,
  output logic          ns_en_q_o
);

  localparam logic [CW-1:0] SAMP_LAST = CW'(SAMPLE_CYCLES - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_CYCLES - 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(NBITS);

  phase_e        state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          nsen_q, nsen_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    nsen_d  = nsen_q;
    unique case (state_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start_i) begin
          state_d = PH_SAMPLE;
          nsen_d  = ns_en_i;
        end
      end
      PH_SAMPLE: begin
        if (cnt_q == SAMP_LAST) begin
          state_d = PH_HOLD;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_HOLD: begin
        state_d = PH_GAP;
        cnt_d   = '0;
      end
      PH_GAP: begin
        if (cnt_q == GAP_LAST) begin
          state_d = PH_CONV;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_CONV: begin
        if (cnt_q == CONV_LAST) begin
          state_d = PH_POST;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_POST: begin
        state_d = PH_IDLE;
        cnt_d   = '0;
      end
      default: begin
        state_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      nsen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      nsen_q  <= nsen_d;
    end
  end

  assign phase_o   = state_q;
  assign cnt_o     = cnt_q;
  assign ns_en_q_o = nsen_q;

endmodule

// File: rtl/nssar_trial_reg.sv
module nssar_trial_reg #(
  parameter int NBITS = 12,
  parameter int CW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] up_o,
  output logic [NBITS-1:0] dn_o
);

  localparam logic [CW-1:0] CONV_LAST = CW'(NBITS);

  logic clr_all;

  // clear when leaving conversion so the final cycle sees mid-rail
  always_comb begin
    clr_all = !conv_i || (cnt_i == CONV_LAST);
  end

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    localparam logic [CW-1:0] SLOT = CW'(NBITS - 1 - b);
    logic load;
    logic up_q, dn_q;

    always_comb begin
      load = conv_i && (cnt_i == SLOT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        up_q <= 1'b0;
        dn_q <= 1'b0;
      end else if (clr_all) begin
        up_q <= 1'b0;
        dn_q <= 1'b0;
      end else if (load) begin
        up_q <= cmp_i;
        dn_q <= !cmp_i;
      end
    end

    assign up_o[b] = up_q;
    assign dn_o[b] = dn_q;
  end

endmodule

// File: rtl/nssar_serializer.sv
module nssar_serializer #(
  parameter int NBITS = 12,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          cmp_i,
  output logic          ser_o,
  output logic          ser_vld_o,
  output logic          done_o
);

  localparam logic [CW-1:0] CONV_LAST = CW'(NBITS);

  logic ser_q, ser_d;
  logic vld_q, vld_d;
  logic done_q, done_d;

  always_comb begin
    ser_d  = conv_i ? cmp_i : ser_q;
    vld_d  = conv_i;
    done_d = conv_i && (cnt_i == CONV_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q  <= 1'b0;
      vld_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ser_q  <= ser_d;
      vld_q  <= vld_d;
      done_q <= done_d;
    end
  end

  assign ser_o     = ser_q;
  assign ser_vld_o = vld_q;
  assign done_o    = done_q;

endmodule

// File: rtl/nssar_seq.sv
module nssar_seq
  import nssar_pkg::*;
#(
  parameter int NBITS         = 12,
  parameter int SAMPLE_CYCLES = 4,
  parameter int GAP_CYCLES    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ns_en_i,
  input  logic             cmp_i,
  output logic             sw_top_o,
  output logic             sw_bot_o,
  output logic             sw_ns_o,
  output logic [NBITS-1:0] dac_up_o,
  output logic [NBITS-1:0] dac_dn_o,
  output logic             ser_o,
  output logic             ser_vld_o,
  output logic             done_o
);

  localparam int CMAX_A = (SAMPLE_CYCLES > GAP_CYCLES) ? SAMPLE_CYCLES : GAP_CYCLES;
  localparam int CMAX   = (CMAX_A > NBITS) ? CMAX_A : NBITS;
  localparam int CW     = $clog2(CMAX + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          ns_en_q;
  logic          conv;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  nssar_phase_ctl #(
    .NBITS        (NBITS),
    .SAMPLE_CYCLES(SAMPLE_CYCLES),
    .GAP_CYCLES   (GAP_CYCLES),
    .CW           (CW)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (start_i),
    .ns_en_i  (ns_en_i),
    .phase_o  (phase),
    .cnt_o    (cnt),
    .ns_en_q_o(ns_en_q)
  );

  assign conv = (phase == PH_CONV);

  nssar_trial_reg #(
    .NBITS(NBITS),
    .CW   (CW)
  ) u_trial (
    .clk   (clk),
    .rst_n (rst_int_n),
    .conv_i(conv),
    .cnt_i (cnt),
    .cmp_i (cmp_i),
    .up_o  (dac_up_o),
    .dn_o  (dac_dn_o)
  );

  nssar_serializer #(
    .NBITS(NBITS),
    .CW   (CW)
  ) u_ser (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .conv_i   (conv),
    .cnt_i    (cnt),
    .cmp_i    (cmp_i),
    .ser_o    (ser_o),
    .ser_vld_o(ser_vld_o),
    .done_o   (done_o)
  );

  // switch decode straight from the phase register
  assign sw_top_o = (phase == PH_SAMPLE);
  assign sw_bot_o = (phase == PH_SAMPLE) || (phase == PH_HOLD);
  assign sw_ns_o  = conv && ns_en_q;

endmodule

// File: rtl/nssar_seq_chk.sv
module nssar_seq_chk #(
  parameter int NBITS = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_top,
  input logic             sw_bot,
  input logic             sw_ns,
  input logic [NBITS-1:0] up,
  input logic [NBITS-1:0] dn,
  input logic             ser_vld,
  input logic             done
);

  a_r3_top_opens_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_top) |-> sw_bot);

  a_r3_top_needs_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    sw_top |-> sw_bot);

  a_r3_mid_while_sampling: assert property (@(posedge clk) disable iff (!rst_n)
    sw_bot |-> (!sw_ns && up == '0 && dn == '0));

  a_r4_gap_after_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_bot) |-> (!sw_ns && up == '0 && dn == '0));

  a_r5_ns_after_open: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_ns) |-> ($past(!sw_bot) && $past(!sw_top)));

  a_r6_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    (up & dn) == '0);

  a_r6_first_trial_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_vld) |-> ($countones(up | dn) == 1));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ser_vld && !sw_ns && !sw_top && !sw_bot && up == '0 && dn == '0));

endmodule

bind nssar_seq nssar_seq_chk #(.NBITS(NBITS)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .sw_top (sw_top_o),
  .sw_bot (sw_bot_o),
  .sw_ns  (sw_ns_o),
  .up     (dac_up_o),
  .dn     (dac_dn_o),
  .ser_vld(ser_vld_o),
  .done   (done_o)
);

// File: tb/nssar_seq_tb_top.sv
module nssar_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 12;
  localparam int S    = 4;
  localparam int G    = 1;
  localparam int CB   = S + G + 2;
  localparam int LAST = CB + NB + 1;

  logic clk;
  logic rst_n, start_i, ns_en_i, cmp_i;
  logic sw_top_o, sw_bot_o, sw_ns_o, ser_o, ser_vld_o, done_o;
  logic [NB-1:0] dac_up_o, dac_dn_o;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  nssar_seq #(.NBITS(NB), .SAMPLE_CYCLES(S), .GAP_CYCLES(G)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ns_en_i(ns_en_i), .cmp_i(cmp_i),
    .sw_top_o(sw_top_o), .sw_bot_o(sw_bot_o), .sw_ns_o(sw_ns_o),
    .dac_up_o(dac_up_o), .dac_dn_o(dac_dn_o),
    .ser_o(ser_o), .ser_vld_o(ser_vld_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [63:0] bundle();
    return {35'd0, sw_top_o, sw_bot_o, sw_ns_o, ser_vld_o, done_o, dac_up_o, dac_dn_o};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one conversion; called at a falling edge while idle
  task automatic run_conv(input logic [NB:0] pat, input logic en, input logic noisy);
    start_i = 1'b1;
    ns_en_i = en;
    cmp_i   = ~pat[NB];
    for (int c = 1; c <= LAST + 1; c++) begin
      logic [NB-1:0] eu, ed;
      logic et, eb, en_s, ev, edn;
      @(negedge clk);
      et   = (c <= S);
      eb   = (c <= S + 1);
      en_s = en && (c >= CB) && (c <= CB + NB);
      ev   = (c > CB) && (c <= LAST);
      edn  = (c == LAST);
      eu   = '0;
      ed   = '0;
      if (c >= CB && c <= CB + NB) begin
        for (int b = 0; b < NB; b++) begin
          if (NB - b <= c - CB) begin
            eu[b] = pat[b + 1];
            ed[b] = ~pat[b + 1];
          end
        end
      end
      if (c <= S + 1)
        check("R3 sampling", bundle(), {35'd0, et, eb, en_s, ev, edn, eu, ed});
      else if (c < CB)
        check("R4 gap", bundle(), {35'd0, et, eb, en_s, ev, edn, eu, ed});
      else if (c < LAST)
        check(noisy ? "R6 R5 R9 R10 conversion" : "R6 R5 conversion", bundle(),
              {35'd0, et, eb, en_s, ev, edn, eu, ed});
      else if (c == LAST)
        check("R8 done", bundle(), {35'd0, et, eb, en_s, ev, edn, eu, ed});
      else
        check(noisy ? "R2 start ignored, idle" : "R1 idle", bundle(), 64'd0);
      if (ev)
        check("R7 R10 serial bit", {63'd0, ser_o}, {63'd0, pat[NB - (c - CB - 1)]});
      // drive inputs for this cycle
      start_i = noisy && (c == 2 || c == CB + 5 || c == LAST);
      ns_en_i = noisy ? ~en : en;
      if (c >= CB && c <= CB + NB) cmp_i = pat[NB - (c - CB)];
      else cmp_i = noisy ^ c[0];
    end
    start_i = 1'b0;
  endtask

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    ns_en_i = 1'b0;
    cmp_i   = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", bundle(), 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R1 idle after reset", bundle(), 64'd0);
      cmp_i   = i[0];
      ns_en_i = i[1];
    end
    begin
      int k = 0;
      for (int p = 0; p < 8192; p += 3) begin
        run_conv(13'(p), k[0], k[1]);
        if (k % 5 == 0) begin
          for (int w = 0; w < 2; w++) begin
            @(negedge clk);
            check("R2 idle without start", bundle(), 64'd0);
          end
        end
        k++;
      end
    end
    run_conv(13'h1FFF, 1'b1, 1'b1);
    run_conv(13'h1000, 1'b0, 1'b0);
    run_conv(13'h0001, 1'b1, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule